// File: doc/BRIEF.md
# Floating-Point Exception Outcome Unit

This unit sits behind a single-precision floating-point datapath and settles how each completed operation ends. For every operation it receives the condition indications from the datapath (invalid operation, zero divisor, possible overflow, possible underflow, possible inexact result and a denormalized input), a flag that the operation is a vector-transform instruction, the sign of the unrounded value, and the rounded candidate word. It keeps the status/control word. That word holds the rounding mode, the denormal-flush mode, the trap enables, the sticky flags and the cause bits.

The unit makes one decision per operation. If any enabled condition is present, it raises a single trap request and suppresses the destination write. Otherwise it writes a result. That result is the candidate word or a substituted default, chosen by the condition, the rounding mode and the flush mode. Software tells the trap causes apart by reading the cause field. The sticky flags build up until software writes the status word. All outputs are registered one clock after the operation is presented.

Top module: `fpx_outcome_unit`

## Requirements
- R1: After reset, `trap_req`, `dst_we`, `dst_data` and `status_q` are all zero. A clock edge without `op_valid` leaves `trap_req` and `dst_we` low one cycle later.
- R2: A denormalized input (`ev_denorm`) with the flush bit clear traps, whatever the enables are. The cause field then shows only the error bit (bit 17). With the flush bit set, a denormalized input does not trap.
- R3: With the invalid enable set, an operation flagged invalid traps. A vector-transform operation (`op_xform`) also traps, whether or not it is flagged invalid. With the enable clear, neither one traps.
- R4: Divide-by-zero, overflow, underflow and inexact each trap only when their own enable bit is set and their condition input is high.
- R5: When several trap causes are present at once, the cause field holds exactly one bit, for the highest-priority cause. Priority from highest to lowest is error, invalid, divide-by-zero, overflow, underflow, inexact.
- R6: On a trap, `trap_req` is high for one cycle and `dst_we` stays low. `dst_data` and the sticky flags keep their previous values.
- R7: On an operation that does not trap, `dst_we` is high one cycle later. Each condition present sets its sticky flag, and the cause field is replaced by the set of conditions present (error bit zero). The flags are cleared only by a status write. An idle cycle leaves the cause field as it was.
- R8: The result of an untrapped invalid operation is the quiet NaN 32'h7FBFFFFF.
- R9: The result of an untrapped divide-by-zero is infinity (exponent all ones, fraction zero) with the sign of the unrounded value.
- R10: The result of an untrapped overflow is infinity of matching sign when the rounding mode is 2'b00 (nearest). It is the largest finite value 0x7F7FFFFF with the sign applied when the mode is 2'b01 (toward zero). Other mode codes act as nearest.
- R11: The result of an untrapped underflow with flush off is the candidate's low 31 bits under the unrounded sign. With flush on, it is a zero carrying that sign.
- R12: When no condition is present, or only inexact is present, the result is the candidate word unchanged. When several untrapped conditions are present, the default is chosen in the order invalid, divide-by-zero, overflow, underflow, inexact.
- R13: Status word layout: bits [1:0] rounding mode; bits [6:2] sticky flags, ordered inexact, underflow, overflow, divide-by-zero, invalid from bit 2 upward; bits [11:7] enables in that same order; bits [17:12] cause, in that same order with error at bit 17; bit 18 flush mode. All other bits read zero. A write (`sr_wr_en`) replaces the word one cycle later. A write overrides any status change from an operation in the same cycle, but that operation still produces its trap or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation completes this cycle |
| op_xform | input | 1 | Operation is a vector-transform instruction |
| ev_invalid | input | 1 | Invalid operation detected |
| ev_divz | input | 1 | Zero divisor detected |
| ev_ovf | input | 1 | Result may overflow |
| ev_unf | input | 1 | Result may underflow |
| ev_inex | input | 1 | Result may be inexact |
| ev_denorm | input | 1 | A denormalized operand was input |
| unr_sign | input | 1 | Sign of the unrounded value |
| rnd_result | input | 32 | Rounded candidate result |
| sr_wr_en | input | 1 | Write the status word |
| sr_wr_data | input | 32 | Value for the status word |
| trap_req | output | 1 | Single shared exception request |
| dst_we | output | 1 | Destination register write enable |
| dst_data | output | 32 | Final result word |
| status_q | output | 32 | Current status/control word |

## Verification
The assertions check on every cycle that a trap never comes with a write and never disturbs the result word. They check that a trap leaves exactly one cause bit, that flags only grow between status writes, and that an idle cycle produces neither trap nor write. They also check that a denormal input with flush off, or a transform with invalid enabled, always traps, and that an untrapped invalid operation yields the quiet NaN. The rest can only be shown by the bench's scenarios, where a behavioural model is compared every clock: the exact default value for each rounding and flush mode, the priority among several conditions at once, a status write colliding with an operation, and the cause field surviving idle cycles.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int SR_W      = 32;
  localparam int NCOND     = 5;             // bit0 inexact .. bit4 invalid
  localparam int NCAUSE    = NCOND + 1;     // plus error at the top
  localparam int RM_LSB    = 0;
  localparam int RM_W      = 2;
  localparam int FLG_LSB   = RM_LSB + RM_W;
  localparam int ENA_LSB   = FLG_LSB + NCOND;
  localparam int CAU_LSB   = ENA_LSB + NCOND;
  localparam int FLUSH_BIT = CAU_LSB + NCAUSE;
  localparam int USED_W    = FLUSH_BIT + 1;
  localparam logic [SR_W-1:0] SR_WMASK = SR_W'((64'd1 << USED_W) - 64'd1);
  localparam int C_INX = 0;
  localparam int C_UNF = 1;
  localparam int C_OVF = 2;
  localparam int C_DVZ = 3;
  localparam int C_INV = 4;
  localparam int C_ERR = 5;

  typedef enum logic [RM_W-1:0] {
    RM_NEAREST = 2'b00,
    RM_TOZERO  = 2'b01
  } rmode_e;
endpackage

// File: rtl/fpx_trap_arbiter.sv
module fpx_trap_arbiter #(
  parameter int NREQ = 6
) (
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] grant,
  output logic            any
);
  logic [NREQ-1:0] higher;

  assign higher[NREQ-1] = 1'b0;
  genvar gi;
  generate
    for (gi = NREQ - 2; gi >= 0; gi--) begin : g_chain
      assign higher[gi] = higher[gi+1] | req[gi+1];
    end
    for (gi = 0; gi < NREQ; gi++) begin : g_grant
      assign grant[gi] = req[gi] & ~higher[gi];
    end
  endgenerate

  assign any = |req;
endmodule

// File: rtl/fpx_default_gen.sv
module fpx_default_gen
  import fpx_pkg::*;
#(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic [NCOND-1:0] cond,
  input  logic             sign,
  input  logic [W-1:0]     rnd,
  input  logic [RM_W-1:0]  rmode,
  input  logic             flush,
  output logic [W-1:0]     result
);
  localparam int FRAC_W = W - 1 - EXP_W;

  function automatic logic [W-1:0] f_qnan();
    return {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};
  endfunction

  function automatic logic [W-1:0] f_inf(input logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  function automatic logic [W-1:0] f_maxfin(input logic s);
    return {s, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
  endfunction

  function automatic logic [W-1:0] f_zero(input logic s);
    return {s, {(W-1){1'b0}}};
  endfunction

  always_comb begin
    if (cond[C_INV])
      result = f_qnan();
    else if (cond[C_DVZ])
      result = f_inf(sign);
    else if (cond[C_OVF])
      result = (rmode == RM_TOZERO) ? f_maxfin(sign) : f_inf(sign);
    else if (cond[C_UNF])
      result = flush ? f_zero(sign) : {sign, rnd[W-2:0]};
    else
      result = rnd;
  end
endmodule

// File: rtl/fpx_status_next.sv
module fpx_status_next
  import fpx_pkg::*;
(
  input  logic [SR_W-1:0]   sr_q,
  input  logic              op_valid,
  input  logic              trap_any,
  input  logic [NCAUSE-1:0] grant,
  input  logic [NCOND-1:0]  cond,
  input  logic              wr_en,
  input  logic [SR_W-1:0]   wr_data,
  output logic [SR_W-1:0]   sr_d
);
  always_comb begin
    sr_d = sr_q;
    if (wr_en) begin
      sr_d = wr_data & SR_WMASK;
    end else if (op_valid) begin
      if (trap_any) begin
        sr_d[CAU_LSB +: NCAUSE] = grant;
      end else begin
        sr_d[CAU_LSB +: NCAUSE] = {1'b0, cond};
        sr_d[FLG_LSB +: NCOND]  = sr_q[FLG_LSB +: NCOND] | cond;
      end
    end
  end
endmodule

// File: rtl/fpx_outcome_unit.sv
module fpx_outcome_unit
  import fpx_pkg::*;
#(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic            op_xform,
  input  logic            ev_invalid,
  input  logic            ev_divz,
  input  logic            ev_ovf,
  input  logic            ev_unf,
  input  logic            ev_inex,
  input  logic            ev_denorm,
  input  logic            unr_sign,
  input  logic [W-1:0]    rnd_result,
  input  logic            sr_wr_en,
  input  logic [SR_W-1:0] sr_wr_data,
  output logic            trap_req,
  output logic            dst_we,
  output logic [W-1:0]    dst_data,
  output logic [SR_W-1:0] status_q
);
  logic [NCOND-1:0]  cond;
  logic [NCOND-1:0]  ena;
  logic              err_cond;
  logic [NCAUSE-1:0] trap_src;
  logic [NCAUSE-1:0] grant;
  logic              trap_any;
  logic [W-1:0]      dflt;
  logic [SR_W-1:0]   sr_d;
  logic              fire_trap;
  logic              fire_write;

  assign cond     = {ev_invalid, ev_divz, ev_ovf, ev_unf, ev_inex};
  assign ena      = status_q[ENA_LSB +: NCOND];
  assign err_cond = ev_denorm & ~status_q[FLUSH_BIT];
  assign trap_src = {err_cond,
                     ena[C_INV] & (cond[C_INV] | op_xform),
                     ena[C_DVZ:C_INX] & cond[C_DVZ:C_INX]};

  fpx_trap_arbiter #(.NREQ(NCAUSE)) arb_i (
    .req   (trap_src),
    .grant (grant),
    .any   (trap_any)
  );

  fpx_default_gen #(.W(W), .EXP_W(EXP_W)) dflt_i (
    .cond   (cond),
    .sign   (unr_sign),
    .rnd    (rnd_result),
    .rmode  (status_q[RM_LSB +: RM_W]),
    .flush  (status_q[FLUSH_BIT]),
    .result (dflt)
  );

  fpx_status_next stat_i (
    .sr_q     (status_q),
    .op_valid (op_valid),
    .trap_any (trap_any),
    .grant    (grant),
    .cond     (cond),
    .wr_en    (sr_wr_en),
    .wr_data  (sr_wr_data),
    .sr_d     (sr_d)
  );

  assign fire_trap  = op_valid & trap_any;
  assign fire_write = op_valid & ~trap_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req <= 1'b0;
      dst_we   <= 1'b0;
      dst_data <= '0;
      status_q <= '0;
    end else begin
      trap_req <= fire_trap;
      dst_we   <= fire_write;
      if (fire_write) dst_data <= dflt;
      status_q <= sr_d;
    end
  end
endmodule

// File: rtl/fpx_outcome_chk.sv
module fpx_outcome_chk
  import fpx_pkg::*;
#(
  parameter int W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            op_xform,
  input logic            ev_invalid,
  input logic            ev_denorm,
  input logic            sr_wr_en,
  input logic            trap_any,
  input logic            trap_req,
  input logic            dst_we,
  input logic [W-1:0]    dst_data,
  input logic [SR_W-1:0] status_q
);
  localparam logic [W-1:0] QNAN = 32'h7FBFFFFF;

  a_r6_no_write_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !dst_we);

  a_r6_hold_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $stable(dst_data));

  a_r5_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && trap_any && !sr_wr_en) |=>
      ($countones(status_q[CAU_LSB +: NCAUSE]) == 1));

  a_r2_error_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ev_denorm && !status_q[FLUSH_BIT] && !sr_wr_en) |=>
      (trap_req && status_q[CAU_LSB + C_ERR]));

  a_r3_xform_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_xform && status_q[ENA_LSB + C_INV]) |=> trap_req);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!trap_req && !dst_we));

  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_wr_en |=> ((status_q[FLG_LSB +: NCOND] & $past(status_q[FLG_LSB +: NCOND]))
                   == $past(status_q[FLG_LSB +: NCOND])));

  a_r8_qnan_default: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ev_invalid && !trap_any) |=> (dst_we && dst_data == QNAN));
endmodule

bind fpx_outcome_unit fpx_outcome_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_xform   (op_xform),
  .ev_invalid (ev_invalid),
  .ev_denorm  (ev_denorm),
  .sr_wr_en   (sr_wr_en),
  .trap_any   (trap_any),
  .trap_req   (trap_req),
  .dst_we     (dst_we),
  .dst_data   (dst_data),
  .status_q   (status_q)
);

// File: tb/fpx_outcome_unit_tb.sv
module fpx_outcome_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 0, op_xform = 0, ev_invalid = 0, ev_divz = 0;
  logic        ev_ovf = 0, ev_unf = 0, ev_inex = 0, ev_denorm = 0, unr_sign = 0;
  logic [31:0] rnd_result = '0;
  logic        sr_wr_en = 0;
  logic [31:0] sr_wr_data = '0;
  logic        trap_req, dst_we;
  logic [31:0] dst_data, status_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;

  // reference model state
  logic        m_trap, m_we;
  logic [31:0] m_data, m_sr;

  always #2 clk = ~clk;  // 250 MHz

  fpx_outcome_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_xform(op_xform),
    .ev_invalid(ev_invalid), .ev_divz(ev_divz), .ev_ovf(ev_ovf),
    .ev_unf(ev_unf), .ev_inex(ev_inex), .ev_denorm(ev_denorm),
    .unr_sign(unr_sign), .rnd_result(rnd_result), .sr_wr_en(sr_wr_en),
    .sr_wr_data(sr_wr_data), .trap_req(trap_req), .dst_we(dst_we),
    .dst_data(dst_data), .status_q(status_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_sr(input int rm, input int en, input int fl);
    return 32'(rm & 3) | (32'(en & 31) << 7) | (32'(fl & 1) << 18);
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_trap = 0; m_we = 0; m_data = 0; m_sr = 0;
    end else begin
      int cause;
      int occ;
      logic [31:0] res;
      logic [31:0] nsr;
      cause = -1;
      occ = (ev_invalid << 4) | (ev_divz << 3) | (ev_ovf << 2) | (ev_unf << 1) | ev_inex;
      if (ev_denorm && !m_sr[18]) cause = 5;
      else if (m_sr[11] && (ev_invalid || op_xform)) cause = 4;
      else if (m_sr[10] && ev_divz) cause = 3;
      else if (m_sr[9] && ev_ovf) cause = 2;
      else if (m_sr[8] && ev_unf) cause = 1;
      else if (m_sr[7] && ev_inex) cause = 0;
      if (ev_invalid) res = 32'h7FBFFFFF;
      else if (ev_divz) res = unr_sign ? 32'hFF800000 : 32'h7F800000;
      else if (ev_ovf) begin
        if (m_sr[1:0] == 2'b01) res = unr_sign ? 32'hFF7FFFFF : 32'h7F7FFFFF;
        else res = unr_sign ? 32'hFF800000 : 32'h7F800000;
      end else if (ev_unf) res = m_sr[18] ? (unr_sign ? 32'h80000000 : 32'h0)
                                          : ((rnd_result & 32'h7FFFFFFF) | (unr_sign ? 32'h80000000 : 32'h0));
      else res = rnd_result;
      nsr = m_sr;
      m_trap = op_valid && cause >= 0;
      m_we = op_valid && cause < 0;
      if (m_we) m_data = res;
      if (op_valid) begin
        nsr = nsr & ~32'h0003F000;
        if (cause >= 0) nsr = nsr | (32'd1 << (12 + cause));
        else nsr = nsr | (32'(occ) << 12) | (32'(occ) << 2);
      end
      if (sr_wr_en) nsr = sr_wr_data & 32'h0007FFFF;
      m_sr = nsr;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R6 trap_req vs model", 32'(trap_req), 32'(m_trap));
      chk("R7 dst_we vs model", 32'(dst_we), 32'(m_we));
      chk("R12 dst_data vs model", dst_data, m_data);
      chk("R13 status vs model", status_q, m_sr);
    end
  end

  task automatic do_op(input bit xf, input bit inv, input bit dz, input bit ov,
                       input bit un, input bit ix, input bit dn, input bit s,
                       input logic [31:0] r);
    @(negedge clk);
    op_valid = 1; op_xform = xf; ev_invalid = inv; ev_divz = dz; ev_ovf = ov;
    ev_unf = un; ev_inex = ix; ev_denorm = dn; unr_sign = s; rnd_result = r;
    @(negedge clk);
    op_valid = 0; op_xform = 0; ev_invalid = 0; ev_divz = 0; ev_ovf = 0;
    ev_unf = 0; ev_inex = 0; ev_denorm = 0;
  endtask

  task automatic wr_sr(input logic [31:0] v);
    @(negedge clk);
    sr_wr_en = 1; sr_wr_data = v;
    @(negedge clk);
    sr_wr_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk("R1 reset trap", 32'(trap_req), 0);
    chk("R1 reset we", 32'(dst_we), 0);
    chk("R1 reset data", dst_data, 0);
    chk("R1 reset status", status_q, 0);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    chk("R1 idle no trap", 32'(trap_req | dst_we), 0);

    do_op(0,0,0,0,0,0,0,0, 32'h3F800000);
    chk("R12 passthrough", dst_data, 32'h3F800000);
    chk("R7 write enable", 32'(dst_we), 1);
    do_op(0,1,0,0,0,0,0,0, 32'h12345678);
    chk("R8 qnan", dst_data, 32'h7FBFFFFF);
    chk("R7 flag V", status_q & 32'h0003F07C, 32'h00010040);
    do_op(0,0,1,0,0,0,0,1, 32'h0);
    chk("R9 neg inf", dst_data, 32'hFF800000);
    do_op(0,0,0,1,0,0,0,0, 32'h0);
    chk("R10 nearest inf", dst_data, 32'h7F800000);
    wr_sr(mk_sr(1, 0, 0));
    chk("R13 write clears flags", status_q, 32'h1);
    do_op(0,0,0,1,0,0,0,1, 32'h0);
    chk("R10 tozero maxfin", dst_data, 32'hFF7FFFFF);
    wr_sr(mk_sr(3, 0, 0));
    do_op(0,0,0,1,0,0,0,0, 32'h0);
    chk("R10 code 3 as nearest", dst_data, 32'h7F800000);
    wr_sr(mk_sr(0, 0, 0));
    do_op(0,0,0,0,1,1,0,1, 32'h00000123);
    chk("R11 denorm kept", dst_data, 32'h80000123);
    wr_sr(mk_sr(0, 0, 1));
    do_op(0,0,0,0,1,0,0,1, 32'h00000123);
    chk("R11 flushed zero", dst_data, 32'h80000000);
    do_op(0,0,0,0,0,1,0,0, 32'h40490FDB);
    chk("R12 inexact passthrough", dst_data, 32'h40490FDB);
    do_op(0,0,0,1,0,1,0,0, 32'h1);
    chk("R12 ovf beats inexact", dst_data, 32'h7F800000);
    repeat (3) @(negedge clk);
    chk("R7 idle keeps cause", status_q[17:12], 6'b000101);

    wr_sr(mk_sr(0, 5'b10000, 0));
    held = dst_data;
    do_op(0,1,0,0,0,0,0,0, 32'h5);
    chk("R3 invalid traps", 32'(trap_req), 1);
    chk("R6 no write", 32'(dst_we), 0);
    chk("R6 data held", dst_data, held);
    chk("R6 flags untouched", status_q[6:2], 0);
    do_op(1,0,0,0,0,0,0,0, 32'h5);
    chk("R3 xform traps", 32'(trap_req), 1);
    wr_sr(mk_sr(0, 0, 0));
    do_op(1,0,0,0,0,0,0,0, 32'h6);
    chk("R3 xform no enable", 32'(trap_req), 0);

    for (int k = 0; k < 4; k++) begin
      wr_sr(mk_sr(0, 1 << k, 0));
      do_op(0,0, k==3, k==2, k==1, k==0, 0,0, 32'h7);
      chk("R4 own enable traps", 32'(trap_req), 1);
      do_op(0,0, k==0, k==1, k==2, k==3, 0,0, 32'h7);
      chk("R4 other enable no trap", 32'(trap_req), 0);
    end

    wr_sr(mk_sr(0, 0, 0));
    do_op(0,0,0,0,0,0,1,0, 32'h8);
    chk("R2 error trap", 32'(trap_req), 1);
    chk("R2 error cause", status_q[17:12], 6'b100000);
    wr_sr(mk_sr(0, 0, 1));
    do_op(0,0,0,0,0,0,1,0, 32'h8);
    chk("R2 flush no trap", 32'(trap_req), 0);

    wr_sr(mk_sr(0, 31, 0));
    do_op(1,1,1,1,1,1,1,0, 32'h9);
    chk("R5 error first", status_q[17:12], 6'b100000);
    do_op(0,1,1,1,1,1,0,0, 32'h9);
    chk("R5 invalid next", status_q[17:12], 6'b010000);
    do_op(0,0,0,1,1,1,0,0, 32'h9);
    chk("R5 overflow next", status_q[17:12], 6'b000100);

    wr_sr(mk_sr(0, 0, 0));
    @(negedge clk);
    op_valid = 1; ev_inex = 1; rnd_result = 32'hA; sr_wr_en = 1; sr_wr_data = 32'hFFFFFFFF;
    @(negedge clk);
    op_valid = 0; ev_inex = 0; sr_wr_en = 0;
    chk("R13 write wins", status_q, 32'h0007FFFF);
    chk("R13 op still writes", 32'(dst_we), 1);

    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      op_valid = $urandom_range(0, 3) != 0;
      op_xform = $urandom_range(0, 7) == 0;
      ev_invalid = $urandom_range(0, 5) == 0;
      ev_divz = $urandom_range(0, 5) == 0;
      ev_ovf = $urandom_range(0, 4) == 0;
      ev_unf = $urandom_range(0, 4) == 0;
      ev_inex = $urandom_range(0, 2) == 0;
      ev_denorm = $urandom_range(0, 9) == 0;
      unr_sign = 1'($urandom);
      rnd_result = $urandom;
      sr_wr_en = $urandom_range(0, 15) == 0;
      sr_wr_data = $urandom & 32'hFFF8_007F;
    end
    @(negedge clk);
    op_valid = 0; sr_wr_en = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule